// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer with a byte-wide control register. It counts qualified ticks up to a selectable power-of-two timeout. When the timeout passes without a clear, it raises a one-clock system reset pulse. Software reads and writes the register through a simple write strobe and a read-data bus. A separate kick input, which stands for the software "pet the dog" operation, restarts the count.

Two static configuration straps pick one of three protection levels. The level sets the state of the watchdog after reset and whether it can ever be switched off. It also sets whether a change of the timeout select must go through an unlock step. The unlock step is a write that sets the unlock flag and the run flag together. That flag then stays up for a short window and clears itself. A disable or a guarded timeout change is accepted only while the flag reads one.

Top module: `wdg_guard`

## Requirements
- R1: The control byte reads bits 7..5 as zero. Bit 4 is the unlock flag, bit 3 is the run flag, and bits 2..0 are the timeout select. After reset the unlock flag and the select are zero.
- R2: A write with bits 4 and 3 both one sets the unlock flag. The flag then reads one for exactly four clock cycles and hardware clears it. A write made in any of those cycles is accepted as unlocked. A new write with both bits set restarts the window. Nothing else sets the flag.
- R3: Writing bit 3 as one starts the watchdog. Writing bit 3 as zero stops it only while the unlock flag reads one; otherwise the run flag stays one.
- R4: Level decoding: always_on_i high gives level 2, whatever compat_i is. compat_i high with always_on_i low gives level 0. Both low gives level 1.
- R5: After reset the run flag is zero at levels 0 and 1 and one at level 2.
- R6: At level 2 the run flag reads one at all times, and writes cannot clear it, even inside an unlock window.
- R7: At level 0 every write loads the timeout select, with or without the unlock flag.
- R8: At levels 1 and 2 a write loads the timeout select only while the unlock flag reads one; otherwise the select keeps its value.
- R9: While running, with the counter at zero, the 2^(BASE_EXP+select)-th tick_i pulse makes wdt_reset_o high for exactly one cycle, in the cycle after that tick's clock edge. The count then restarts from zero.
- R10: kick_i zeroes the counter. A write that changes the stored select also zeroes the counter, so the new timeout is counted in full.
- R11: While the run flag is zero the counter stays at zero and wdt_reset_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| compat_i | input | 1 | Static strap, compatibility level select |
| always_on_i | input | 1 | Static strap, forces the always-running level |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| tick_i | input | 1 | Watchdog tick enable |
| kick_i | input | 1 | Counter clear |
| wdt_reset_o | output | 1 | One-cycle system reset pulse |

## Verification
The bound checker checks these rules on every cycle:
- the reserved bits read as zero;
- the run flag is always on at level 2;
- the run flag never drops while the unlock flag is low;
- the select is frozen outside the window at the guarded levels;
- the unlock flag rises only after a qualifying write and never outlives its four-cycle window;
- the reset pulse lasts one cycle and appears only while the watchdog runs.

Only the directed scenarios can show the exact cycle of each timeout under different selects, kicks and select changes. They also check the initial state at each level and that a write at the last window cycle succeeds while the next one fails.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        SAFE_L0 = 2'd0,
        SAFE_L1 = 2'd1,
        SAFE_L2 = 2'd2
    } safety_e;

    typedef struct packed {
        logic       unlock;
        logic       run;
        logic [2:0] sel;
    } ctl_s;

    localparam int CTL_W    = 8;
    localparam int SEL_W    = 3;
    localparam int UNLK_BIT = 4;
    localparam int RUN_BIT  = 3;

    function automatic safety_e decode_level(input logic compat, input logic aon);
        if (aon)         return SAFE_L2;
        else if (compat) return SAFE_L0;
        else             return SAFE_L1;
    endfunction

    function automatic ctl_s unpack_ctl(input logic [CTL_W-1:0] b);
        ctl_s c;
        c.unlock = b[UNLK_BIT];
        c.run    = b[RUN_BIT];
        c.sel    = b[SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] pack_ctl(input ctl_s c);
        return {3'b000, c.unlock, c.run, c.sel};
    endfunction

endpackage

// File: rtl/wdg_level_dec.sv
module wdg_level_dec
    import wdg_pkg::*;
(
    input  logic    compat_i,
    input  logic    always_on_i,
    output safety_e level_o,
    output logic    start_on_o,
    output logic    can_stop_o,
    output logic    sel_guarded_o
);
    always_comb begin
        level_o       = decode_level(compat_i, always_on_i);
        start_on_o    = 1'b0;
        can_stop_o    = 1'b1;
        sel_guarded_o = 1'b1;
        unique case (level_o)
            SAFE_L0: sel_guarded_o = 1'b0;
            SAFE_L1: ;
            SAFE_L2: begin
                start_on_o = 1'b1;
                can_stop_o = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
    import wdg_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_on_i,
    input  logic             can_stop_i,
    input  logic             sel_guarded_i,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output ctl_s             ctl_o,
    output logic             sel_reload_o
);
    localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [TW-1:0] T_LOAD = TW'(WINDOW - 1);

    ctl_s          cur_q, nxt;
    logic [TW-1:0] tmr_q, tmr_d;
    ctl_s          wd;
    logic          arm;
    logic          sel_ok;

    always_comb begin
        wd     = unpack_ctl(wr_data_i);
        arm    = wr_en_i && wd.unlock && wd.run;
        sel_ok = wr_en_i && (!sel_guarded_i || cur_q.unlock);
        nxt    = cur_q;
        tmr_d  = tmr_q;

        if (wr_en_i) begin
            if (wd.run)
                nxt.run = 1'b1;
            else if (cur_q.unlock && can_stop_i)
                nxt.run = 1'b0;
        end
        if (sel_ok)
            nxt.sel = wd.sel;
        if (!can_stop_i)
            nxt.run = 1'b1;

        if (arm) begin
            nxt.unlock = 1'b1;
            tmr_d      = T_LOAD;
        end else if (cur_q.unlock) begin
            if (tmr_q == '0)
                nxt.unlock = 1'b0;
            else
                tmr_d = tmr_q - 1'b1;
        end

        sel_reload_o = sel_ok && (wd.sel != cur_q.sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.unlock <= 1'b0;
            cur_q.run    <= start_on_i;
            cur_q.sel    <= '0;
            tmr_q        <= '0;
        end else begin
            cur_q <= nxt;
            tmr_q <= tmr_d;
        end
    end

    assign ctl_o = cur_q;
endmodule

// File: rtl/wdg_count.sv
module wdg_count
    import wdg_pkg::*;
#(
    parameter int BASE_EXP = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             zero_i,
    input  logic             tick_i,
    output logic             expire_o
);
    localparam int CW = BASE_EXP + (1 << SEL_W) + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          hit;

    always_comb begin
        last = (ONE << (BASE_EXP + int'(sel_i))) - ONE;
        hit  = run_i && tick_i && !zero_i && (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= hit;
            if (!run_i || zero_i || hit)
                cnt_q <= '0;
            else if (tick_i)
                cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int WINDOW   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       compat_i,
    input  logic       always_on_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       tick_i,
    input  logic       kick_i,
    output logic       wdt_reset_o
);
    safety_e level;
    logic    start_on, can_stop, sel_guarded;
    ctl_s    ctl;
    logic    sel_reload;

    wdg_level_dec dec_i (
        .compat_i      (compat_i),
        .always_on_i   (always_on_i),
        .level_o       (level),
        .start_on_o    (start_on),
        .can_stop_o    (can_stop),
        .sel_guarded_o (sel_guarded)
    );

    wdg_ctl_reg #(.WINDOW(WINDOW)) reg_i (
        .clk           (clk),
        .rst           (rst),
        .start_on_i    (start_on),
        .can_stop_i    (can_stop),
        .sel_guarded_i (sel_guarded),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .ctl_o         (ctl),
        .sel_reload_o  (sel_reload)
    );

    wdg_count #(.BASE_EXP(BASE_EXP)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .run_i    (ctl.run),
        .sel_i    (ctl.sel),
        .zero_i   (kick_i || sel_reload),
        .tick_i   (tick_i),
        .expire_o (wdt_reset_o)
    );

    assign rd_data_o = pack_ctl(ctl);
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
    parameter int WINDOW = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       compat_i,
    input logic       always_on_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] rd_data_o,
    input logic       wdt_reset_o
);
    logic [7:0] age_q;
    logic       arm_wr;

    assign arm_wr = wr_en_i && wr_data_i[4] && wr_data_i[3];

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= 8'hFF;
        else if (arm_wr)
            age_q <= 8'h00;
        else if (age_q != 8'hFF)
            age_q <= age_q + 8'h01;
    end

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[7:5] == 3'b000);

    a_r2_unlock_window: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[4] |-> (int'(age_q) < WINDOW));

    a_r2_unlock_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data_o[4]) |-> $past(arm_wr));

    a_r3_no_stop_locked: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_data_o[3]) && !$past(rd_data_o[4])) |-> rd_data_o[3]);

    a_r6_level2_runs: assert property (@(posedge clk) disable iff (rst)
        always_on_i |-> rd_data_o[3]);

    a_r8_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        (!(compat_i && !always_on_i) && !$past(rd_data_o[4])) |-> $stable(rd_data_o[2:0]));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_o |=> !wdt_reset_o);

    a_r11_pulse_needs_run: assert property (@(posedge clk) disable iff (rst)
        wdt_reset_o |-> $past(rd_data_o[3]));
endmodule

bind wdg_guard wdg_guard_chk #(.WINDOW(WINDOW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .compat_i    (compat_i),
    .always_on_i (always_on_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .wdt_reset_o (wdt_reset_o)
);

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb_top;
    localparam int BASE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       compat_i = 1'b0;
    logic       always_on_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       tick_i = 1'b0;
    logic       kick_i = 1'b0;
    logic       wdt_reset_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wdg_guard #(.BASE_EXP(BASE), .WINDOW(4)) dut_i (
        .clk(clk), .rst(rst), .compat_i(compat_i), .always_on_i(always_on_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .tick_i(tick_i), .kick_i(kick_i), .wdt_reset_o(wdt_reset_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic compat, input logic aon);
        @(negedge clk);
        rst = 1'b1; compat_i = compat; always_on_i = aon;
        tick_i = 1'b0; kick_i = 1'b0; wr_en_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive at a negedge, sampled at the next posedge, return at the following negedge
    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = 8'h00;
    endtask

    // kick with ticks off, then run ticks and expect the pulse after n ticks
    task automatic expect_timeout(input int n, input string tag);
        tick_i = 1'b0; kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0; tick_i = 1'b1;
        repeat (n - 1) @(negedge clk);
        check({tag, " quiet before timeout"}, wdt_reset_o, 0);
        @(negedge clk);
        check({tag, " pulse at timeout"}, wdt_reset_o, 1);
        @(negedge clk);
        check({tag, " pulse one cycle"}, wdt_reset_o, 0);
        repeat (n - 2) @(negedge clk);
        check({tag, " restart quiet"}, wdt_reset_o, 0);
        @(negedge clk);
        check({tag, " restart pulse"}, wdt_reset_o, 1);
        tick_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_states();
        do_reset(1'b1, 1'b0);
        check("R1 R5 level0 reset byte", rd_data_o, 8'h00);
        do_reset(1'b0, 1'b0);
        check("R1 R5 level1 reset byte", rd_data_o, 8'h00);
        do_reset(1'b0, 1'b1);
        check("R4 R5 level2 reset byte", rd_data_o, 8'h08);
        do_reset(1'b1, 1'b1);
        check("R4 level2 with compat reset byte", rd_data_o, 8'h08);
    endtask

    task automatic t_window();
        do_reset(1'b0, 1'b0);
        wr(8'hF8);
        check("R1 R2 arm write reads back", rd_data_o, 8'h18);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 unlock held", rd_data_o[4], 1);
        end
        @(negedge clk);
        check("R2 unlock cleared after four", rd_data_o[4], 0);
        wr(8'h10);
        check("R2 unlock needs run bit", rd_data_o[4], 0);
    endtask

    task automatic t_stop_rules();
        do_reset(1'b0, 1'b0);
        wr(8'h08);
        check("R3 run set", rd_data_o[3], 1);
        wr(8'h00);
        check("R3 stop refused when locked", rd_data_o[3], 1);
        wr(8'h18);
        wr(8'h00);
        check("R3 stop inside window", rd_data_o[3], 0);
        // last window cycle is accepted
        wr(8'h18);
        repeat (3) @(negedge clk);
        wr(8'h00);
        check("R2 R3 stop at last window cycle", rd_data_o[3], 0);
        // one cycle too late
        wr(8'h18);
        repeat (4) @(negedge clk);
        wr(8'h00);
        check("R2 R3 stop after window refused", rd_data_o[3], 1);
        // restart of window
        wr(8'h18);
        repeat (3) @(negedge clk);
        wr(8'h18);
        repeat (3) @(negedge clk);
        wr(8'h00);
        check("R2 rearm extends window", rd_data_o[3], 0);
    endtask

    task automatic t_sel_rules();
        do_reset(1'b0, 1'b0);
        wr(8'h0B);
        check("R8 level1 sel locked", rd_data_o, 8'h08);
        wr(8'h18);
        wr(8'h0B);
        check("R8 level1 sel in window", rd_data_o[2:0], 3);
        do_reset(1'b1, 1'b0);
        wr(8'h05);
        check("R7 level0 free sel", rd_data_o, 8'h05);
        wr(8'h08);
        wr(8'h00);
        check("R3 R7 level0 stop refused", rd_data_o, 8'h08);
    endtask

    task automatic t_level2();
        do_reset(1'b0, 1'b1);
        wr(8'h00);
        check("R6 level2 plain clear ignored", rd_data_o[3], 1);
        wr(8'h18);
        wr(8'h00);
        check("R6 level2 clear in window ignored", rd_data_o[3], 1);
        repeat (4) @(negedge clk);
        wr(8'h0A);
        check("R8 level2 sel locked", rd_data_o[2:0], 0);
        wr(8'h18);
        wr(8'h0A);
        check("R8 level2 sel in window", rd_data_o[2:0], 2);
    endtask

    task automatic t_timeouts();
        do_reset(1'b0, 1'b0);
        wr(8'h08);
        expect_timeout(1 << BASE, "R9 sel0");
        wr(8'h18);
        wr(8'h0A);
        expect_timeout(1 << (BASE + 2), "R9 sel2");
        do_reset(1'b1, 1'b0);
        wr(8'h09);
        expect_timeout(1 << (BASE + 1), "R9 R10 level0 sel1");
    endtask

    task automatic t_zeroing();
        do_reset(1'b1, 1'b0);
        wr(8'h08);
        tick_i = 1'b1;
        repeat (10) @(negedge clk);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        repeat ((1 << BASE) - 1) @(negedge clk);
        check("R10 kick restarts quiet", wdt_reset_o, 0);
        @(negedge clk);
        check("R10 kick restarts pulse", wdt_reset_o, 1);
        repeat (10) @(negedge clk);
        wr(8'h09);
        repeat ((1 << (BASE + 1)) - 1) @(negedge clk);
        check("R10 sel change restarts quiet", wdt_reset_o, 0);
        @(negedge clk);
        check("R10 sel change restarts pulse", wdt_reset_o, 1);
        tick_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle();
        int seen = 0;
        do_reset(1'b0, 1'b0);
        tick_i = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wdt_reset_o) seen++;
        end
        tick_i = 1'b0;
        check("R11 no pulse while stopped", seen, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<200000", cyc);
            finish_run();
        end
    end

    initial begin
        t_reset_states();
        t_window();
        t_stop_rules();
        t_sel_rules();
        t_level2();
        t_timeouts();
        t_zeroing();
        t_idle();
        finish_run();
    end
endmodule